// File: doc/BRIEF.md
# Dual DAC Byte-Loaded Update Register Front End

This block sits between a narrow host bus and two digital-to-analog converter channels. Each channel owns a 16-bit staging register that the host fills one byte at a time: the low byte first, then the high byte. A second path loads the whole code in a single word write. The staged code reaches the channel output only on an update event. A static mode input, meant to be strapped like a board jumper, picks what counts as an update event. In per-channel mode, a completed high-byte or word write updates that channel. In synchronized mode, both channels are loaded first, and then any bus read of a DAC register address moves both staged codes to both outputs on the same edge.

The output width is a parameter. With `CODE_W = 12` the block is the 12-bit variant: the code is left-justified in the 16-bit staging word and the four low bits are discarded. A separate range register holds one 2-bit output range selector per channel. The analog conversion itself is not part of the block.

Top module: `dual_dac_loader`

## Requirements
- R1: While `rst_n` is low, both staging registers, both output codes and both range fields go to zero.
- R2: A byte write (`bus_word` = 0) to channel n's low-byte offset `DAC_BASE + 2n` changes only bits 7:0 of that channel's staging register. Neither output changes, in either mode.
- R3: When `xfer_sync` = 0, a byte write to channel n's high-byte offset `DAC_BASE + 2n + 1` sets that channel's output on the same clock edge to the complete staged word {written byte, staged low byte}. The other channel's output keeps its value.
- R4: When `xfer_sync` = 1, byte and word writes to the DAC offsets change staging only. Both outputs keep their values.
- R5: When `xfer_sync` = 1, a read strobe to any of the four DAC offsets copies both staging registers to both outputs on the same edge.
- R6: A read strobe has no effect on the outputs when `xfer_sync` = 0. A read strobe to an address outside the four DAC offsets has no effect in either mode.
- R7: A word write (`bus_word` = 1) to offset `DAC_BASE + 2n` loads all 16 staging bits of channel n at once. When `xfer_sync` = 0 it also updates that channel's output, like a high-byte write.
- R8: With `CODE_W` = 12, an output carries bits 15:4 of the staged word, and bits 3:0 of a write have no effect on it. With `CODE_W` = 16, it carries the whole word.
- R9: A write to `RANGE_ADDR` sets channel 0's range from data bits 5:4 and channel 1's range from bits 7:6, and ignores the other bits. The range code means: 0 = ±5 V, 1 = ±10 V, 2 = 0 to 5 V, 3 = 0 to 10 V.
- R10: A write to `RANGE_ADDR` leaves both DAC output codes unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Register offset of the current access |
| bus_wdata | input | 16 | Write data; a byte write uses bits 7:0 |
| bus_we | input | 1 | Write strobe, one cycle per access |
| bus_word | input | 1 | 1 = 16-bit word write, 0 = byte write |
| bus_re | input | 1 | Read strobe, one cycle per access |
| xfer_sync | input | 1 | Update mode: 0 = per-channel, 1 = synchronized on read |
| dac0_code | output | CODE_W | Channel 0 output code |
| dac1_code | output | CODE_W | Channel 1 output code |
| dac0_range | output | 2 | Channel 0 range selector |
| dac1_range | output | 2 | Channel 1 range selector |

## Verification
The codes cover all-zeros, all-ones, split-byte patterns and a multiplicative spread. Each is driven through the byte path and the word path. In per-channel mode, checking after the low byte and again after the high byte shows whether the output moves before the code is complete. In synchronized mode, the outputs are checked after all four bytes are written, then after reads outside the DAC window, then after a read to each DAC offset in turn. This shows whether the trigger is the write, any read, or a DAC-window read. A 16-step sweep of the low nibble under a fixed high part runs against a 12-bit and a 16-bit instance side by side, which shows the truncation. All 256 range-register byte values are tried.

// File: rtl/dual_dac_loader.sv
module dual_dac_loader #(
  parameter int CODE_W     = 16,
  parameter int ADDR_W     = 4,
  parameter int DAC_BASE   = 4,
  parameter int RANGE_ADDR = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  input  logic              bus_we,
  input  logic              bus_word,
  input  logic              bus_re,
  input  logic              xfer_sync,
  output logic [CODE_W-1:0] dac0_code,
  output logic [CODE_W-1:0] dac1_code,
  output logic [1:0]        dac0_range,
  output logic [1:0]        dac1_range
);
  localparam int NCH = 2;

  logic [ADDR_W-1:0] off;
  logic              in_dac;
  logic              xfer_all;
  logic              rng_wr;
  logic [15:0]       stg    [NCH];
  logic [CODE_W-1:0] code_q [NCH];
  logic [1:0]        rng_q  [NCH];

  assign off      = bus_addr - ADDR_W'(DAC_BASE);
  assign in_dac   = (bus_addr >= ADDR_W'(DAC_BASE)) &&
                    (bus_addr <  ADDR_W'(DAC_BASE + 2*NCH));
  assign xfer_all = bus_re && in_dac && xfer_sync;
  assign rng_wr   = bus_we && (bus_addr == ADDR_W'(RANGE_ADDR));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic        sel;
    logic        lo_wr;
    logic        hi_wr;
    logic        wd_wr;
    logic        load;
    logic [15:0] nxt;

    assign sel   = in_dac && (off[1] == 1'(c));
    assign lo_wr = bus_we && sel && !off[0] && !bus_word;
    assign hi_wr = bus_we && sel &&  off[0] && !bus_word;
    assign wd_wr = bus_we && sel && !off[0] &&  bus_word;
    assign load  = (!xfer_sync && (hi_wr || wd_wr)) || xfer_all;

    always_comb begin
      nxt = stg[c];
      if (lo_wr) nxt[7:0]  = bus_wdata[7:0];
      if (hi_wr) nxt[15:8] = bus_wdata[7:0];
      if (wd_wr) nxt       = bus_wdata;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stg[c]    <= '0;
        code_q[c] <= '0;
        rng_q[c]  <= '0;
      end else begin
        stg[c] <= nxt;
        if (load)   code_q[c] <= nxt[15 -: CODE_W];
        if (rng_wr) rng_q[c]  <= bus_wdata[4 + 2*c +: 2];
      end
    end
  end

  assign dac0_code  = code_q[0];
  assign dac1_code  = code_q[1];
  assign dac0_range = rng_q[0];
  assign dac1_range = rng_q[1];
endmodule

module dual_dac_loader_chk #(
  parameter int CODE_W     = 16,
  parameter int ADDR_W     = 4,
  parameter int DAC_BASE   = 4,
  parameter int RANGE_ADDR = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [15:0]       bus_wdata,
  input logic              bus_we,
  input logic              bus_word,
  input logic              bus_re,
  input logic              xfer_sync,
  input logic [CODE_W-1:0] dac0_code,
  input logic [CODE_W-1:0] dac1_code,
  input logic [1:0]        dac0_range,
  input logic [1:0]        dac1_range,
  input logic [15:0]       stg0,
  input logic [15:0]       stg1
);
  localparam int DROP = 16 - CODE_W;

  logic dac_hit;
  assign dac_hit = (bus_addr >= ADDR_W'(DAC_BASE)) &&
                   (bus_addr <  ADDR_W'(DAC_BASE + 4));

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (dac0_code == '0) && (dac1_code == '0) &&
               (dac0_range == 2'd0) && (dac1_range == 2'd0));

  assert_low_byte_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !bus_word && !bus_re && bus_addr == ADDR_W'(DAC_BASE))
    |=> $stable(dac0_code) && $stable(dac1_code));

  assert_high_byte_loads_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_sync && bus_we && !bus_word && !bus_re && bus_addr == ADDR_W'(DAC_BASE + 3))
    |=> (dac1_code == CODE_W'({$past(bus_wdata[7:0]), $past(stg1[7:0])} >> DROP)) &&
        $stable(dac0_code));

  assert_sync_no_read_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_sync && !bus_re) |=> $stable(dac0_code) && $stable(dac1_code));

  assert_sync_read_moves_both_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_sync && bus_re && !bus_we && dac_hit)
    |=> (dac0_code == CODE_W'($past(stg0) >> DROP)) &&
        (dac1_code == CODE_W'($past(stg1) >> DROP)));

  assert_outside_read_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && !bus_we && !dac_hit) |=> $stable(dac0_code) && $stable(dac1_code));

  assert_range_fields_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(RANGE_ADDR))
    |=> (dac0_range == $past(bus_wdata[5:4])) && (dac1_range == $past(bus_wdata[7:6])));
endmodule

bind dual_dac_loader dual_dac_loader_chk #(
  .CODE_W(CODE_W), .ADDR_W(ADDR_W), .DAC_BASE(DAC_BASE), .RANGE_ADDR(RANGE_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_we(bus_we), .bus_word(bus_word), .bus_re(bus_re), .xfer_sync(xfer_sync),
  .dac0_code(dac0_code), .dac1_code(dac1_code),
  .dac0_range(dac0_range), .dac1_range(dac1_range),
  .stg0(stg[0]), .stg1(stg[1])
);

// File: tb/tb_dual_dac_loader.sv
`timescale 1ns/1ps
module tb_dual_dac_loader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic        bus_we = 1'b0, bus_word = 1'b0, bus_re = 1'b0, xfer_sync = 1'b0;
  logic [15:0] w0, w1;
  logic [11:0] n0, n1;
  logic [1:0]  wr0, wr1, nr0, nr1;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [15:0] e0, e1;

  always #2.5 clk = ~clk;

  dual_dac_loader #(.CODE_W(16)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_word(bus_word), .bus_re(bus_re), .xfer_sync(xfer_sync),
    .dac0_code(w0), .dac1_code(w1), .dac0_range(wr0), .dac1_range(wr1));

  dual_dac_loader #(.CODE_W(12)) dut_n (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_word(bus_word), .bus_re(bus_re), .xfer_sync(xfer_sync),
    .dac0_code(n0), .dac1_code(n1), .dac0_range(nr0), .dac1_range(nr1));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_out(string req);
    check(req, 32'(w0), 32'(e0));
    check(req, 32'(w1), 32'(e1));
    check(req, 32'(n0), 32'(e0[15:4]));
    check(req, 32'(n1), 32'(e1[15:4]));
  endtask

  task automatic access(logic [3:0] a, logic [15:0] d, logic we, logic wd, logic re);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = we; bus_word = wd; bus_re = re;
    @(negedge clk);
    bus_we = 1'b0; bus_word = 1'b0; bus_re = 1'b0;
  endtask

  function automatic logic [15:0] pat(int i);
    case (i)
      0: return 16'h0000;
      1: return 16'hFFFF;
      2: return 16'h00FF;
      3: return 16'hFF00;
      default: return 16'(i * 40503 + 4660);
    endcase
  endfunction

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    e0 = '0; e1 = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_out("R1");
    check("R1", 32'({wr0, wr1, nr0, nr1}), 32'd0);

    // per-channel mode: low byte stages only (R2), high byte updates (R3)
    for (int c = 0; c < 2; c++) begin
      for (int i = 0; i < 32; i++) begin
        logic [15:0] v;
        v = pat(i);
        access(4'(4 + 2*c), {8'h00, v[7:0]}, 1, 0, 0);
        chk_out("R2");
        access(4'(5 + 2*c), {8'hEE, v[15:8]}, 1, 0, 0);
        if (c == 0) e0 = v; else e1 = v;
        chk_out("R3");
      end
    end

    // synchronized mode: writes hold (R4), outside reads hold (R6), DAC reads move both (R5)
    xfer_sync = 1'b1;
    for (int i = 0; i < 32; i++) begin
      logic [15:0] a, b;
      a = pat(i + 7);
      b = pat(i + 40);
      access(4'd4, {8'h00, a[7:0]},  1, 0, 0);
      access(4'd5, {8'h00, a[15:8]}, 1, 0, 0);
      access(4'd6, {8'h00, b[7:0]},  1, 0, 0);
      access(4'd7, {8'h00, b[15:8]}, 1, 0, 0);
      chk_out("R4");
      access(4'd0, 16'h0, 0, 0, 1);
      access(4'd10, 16'h0, 0, 0, 1);
      chk_out("R6");
      access(4'(4 + (i % 4)), 16'h0, 0, 0, 1);
      e0 = a; e1 = b;
      chk_out("R5");
    end
    access(4'd6, 16'h1357, 1, 1, 0);
    chk_out("R4");
    access(4'd5, 16'h0, 0, 0, 1);
    e1 = 16'h1357;
    chk_out("R5");

    // per-channel mode: reads do nothing (R6); partial then complete code
    xfer_sync = 1'b0;
    access(4'd4, 16'h003C, 1, 0, 0);
    for (int a = 4; a < 8; a++) begin
      access(4'(a), 16'h0, 0, 0, 1);
      chk_out("R6");
    end
    access(4'd5, 16'h00A7, 1, 0, 0);
    e0 = 16'hA73C;
    chk_out("R3");

    // word path (R7)
    for (int i = 0; i < 32; i++) begin
      logic [15:0] v;
      v = pat(i + 3);
      access(4'(4 + 2*(i % 2)), v, 1, 1, 0);
      if (i % 2 == 0) e0 = v; else e1 = v;
      chk_out("R7");
    end

    // low nibble sweep: 12-bit ignores, 16-bit follows (R8)
    for (int n = 0; n < 16; n++) begin
      access(4'd4, {12'hA5C, 4'(n)}, 1, 1, 0);
      e0 = {12'hA5C, 4'(n)};
      check("R8", 32'(n0), 32'h0A5C);
      check("R8", 32'(w0), 32'(e0));
    end

    // range register (R9), outputs untouched (R10)
    for (int d = 0; d < 256; d++) begin
      access(4'd10, 16'(d) | 16'hAB00, 1, 0, 0);
      check("R9", 32'(wr0), 32'((d >> 4) & 3));
      check("R9", 32'(wr1), 32'((d >> 6) & 3));
      check("R9", 32'(nr0), 32'((d >> 4) & 3));
      if (d % 32 == 0) chk_out("R10");
    end
    chk_out("R10");

    // reset mid-run clears everything (R1)
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    e0 = '0; e1 = '0;
    chk_out("R1");
    check("R1", 32'({wr0, wr1}), 32'd0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule